// File: doc/BRIEF.md
# Protection-Entry Configuration Write Legaliser

This block holds one 8-bit memory-protection entry configuration and decides what value is stored when software writes a new byte to it. A purely combinational legaliser takes the current stored value, the proposed byte, the machine-lockdown flag, the rule-lock-bypass flag and a flag that says the protection grain is nonzero. It produces the only value the entry may legally take. A thin register stage captures that value on a write strobe.

The byte layout is fixed, because the permission checker next to this block decodes it:
- bit 0 is R (read);
- bit 1 is W (write);
- bit 2 is X (execute);
- bits 4:3 select the match mode: 0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned;
- bits 6:5 are reserved;
- bit 7 is L (lock).

When lockdown is on, the combination R=0/W=1 marks a shared region and is kept. When lockdown is off, that combination is reserved.

The legaliser applies its rules in a fixed order:
1. Lock protection.
2. Reserved-bit clearing.
3. The R/W fix when lockdown is off.
4. Rejection of new executable or shared locked rules under lockdown.
5. The coarse-grain replacement of the four-byte match mode.

Top module: `pmpcfg_guard`

## Requirements
- R1: After reset the stored configuration reads 0x00.
- R2: While the write strobe is low the stored configuration does not change, whatever the other inputs do.
- R3: When the stored L bit (bit 7) is 1 and the bypass flag is 0, a write leaves the stored value unchanged.
- R4: When the bypass flag is 1, an entry whose L bit is 1 accepts a write like an unlocked entry.
- R5: Bits 6:5 of the stored value are always 0 after any write.
- R6: With lockdown off, a written byte with R=0 (bit 0) and W=1 (bit 1) is stored with W cleared, and X and the other fields are kept.
- R7: With lockdown on, a written byte with R=0 and W=1 keeps both bits as written (shared region), unless R8 rejects it.
- R8: With lockdown on, bypass 0 and the written L bit 1, a write whose X,W,R (bits 2:0) equal 100, 010, 110 or 101 is rejected. Only the match-mode replacement of R10 may then alter the old value.
- R9: The same X,W,R combinations are accepted under lockdown when bypass is 1 or the written L bit is 0. The combination X,W,R=111 with L=1 is always accepted.
- R10: When the grain flag is 1 and the resulting match mode (bits 4:3) is 2, the mode is stored as 0. When the grain flag is 0, mode 2 is stored as written.
- R11: The legalised value appears on the output after the first rising clock edge at which the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the entry |
| wr_byte | input | 8 | Proposed configuration byte |
| lockdown | input | 1 | Machine-lockdown flag |
| bypass | input | 1 | Rule-lock-bypass flag |
| coarse_grain | input | 1 | Protection grain is 1 or more |
| cfg_out | output | 8 | Stored, legalised configuration |

## Verification
The hardest case to reach is a rejected lockdown write that still changes the entry. This happens when the old value holds the four-byte mode, and the grain flag is raised only at the moment of the rejected write. The stimulus first stores mode 2 with the grain flag low. It then turns lockdown on and writes locked execute-only or write-only bytes, with and without the grain flag. After that it checks that a locked entry ignores writes until bypass is raised. A long stretch of random writes, with every flag toggling, follows the directed part so that the lock, reject and grain rules interact in many orders.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_RANGE = 2'd1,
        MATCH_WORD  = 2'd2,
        MATCH_POW2  = 2'd3
    } match_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        match_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
    } entry_state_t;

endpackage

// File: rtl/pmpcfg_lock_eval.sv
module pmpcfg_lock_eval
    import pmpcfg_pkg::*;
(
    input  cfg_t cur_cfg,
    input  logic bypass,
    output logic frozen
);
    always_comb begin
        frozen = cur_cfg.lock & ~bypass;
    end
endmodule

// File: rtl/pmpcfg_sanitise.sv
module pmpcfg_sanitise
    import pmpcfg_pkg::*;
(
    input  cfg_t raw_cfg,
    input  logic lockdown,
    output cfg_t clean_cfg
);
    always_comb begin
        clean_cfg      = raw_cfg;
        clean_cfg.rsvd = '0;
        // R=0/W=1 is reserved outside lockdown; inside it names a shared region
        if (!lockdown && !raw_cfg.r && raw_cfg.w) begin
            clean_cfg.w = 1'b0;
        end
    end
endmodule

// File: rtl/pmpcfg_lockdown_gate.sv
module pmpcfg_lockdown_gate
    import pmpcfg_pkg::*;
(
    input  cfg_t new_cfg,
    input  logic lockdown,
    input  logic bypass,
    output logic reject
);
    logic risky_perm;

    always_comb begin
        unique case ({new_cfg.x, new_cfg.w, new_cfg.r})
            3'b100, 3'b010, 3'b110, 3'b101: risky_perm = 1'b1;
            default:                        risky_perm = 1'b0;
        endcase
        reject = lockdown & ~bypass & new_cfg.lock & risky_perm;
    end
endmodule

// File: rtl/pmpcfg_grain_fix.sv
module pmpcfg_grain_fix
    import pmpcfg_pkg::*;
(
    input  cfg_t in_cfg,
    input  logic coarse_grain,
    output cfg_t out_cfg
);
    always_comb begin
        out_cfg = in_cfg;
        if (coarse_grain && in_cfg.mode == MATCH_WORD) begin
            out_cfg.mode = MATCH_OFF;
        end
    end
endmodule

// File: rtl/pmpcfg_guard.sv
module pmpcfg_guard
    import pmpcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_byte,
    input  logic             lockdown,
    input  logic             bypass,
    input  logic             coarse_grain,
    output logic [CFG_W-1:0] cfg_out
);
    entry_state_t state_d, state_q;
    logic frozen, reject;
    cfg_t clean_cfg, chosen_cfg, fixed_cfg;

    pmpcfg_lock_eval u_lock (
        .cur_cfg (state_q.cfg),
        .bypass  (bypass),
        .frozen  (frozen)
    );

    pmpcfg_sanitise u_san (
        .raw_cfg   (cfg_t'(wr_byte)),
        .lockdown  (lockdown),
        .clean_cfg (clean_cfg)
    );

    pmpcfg_lockdown_gate u_gate (
        .new_cfg  (clean_cfg),
        .lockdown (lockdown),
        .bypass   (bypass),
        .reject   (reject)
    );

    assign chosen_cfg = reject ? state_q.cfg : clean_cfg;

    pmpcfg_grain_fix u_grain (
        .in_cfg       (chosen_cfg),
        .coarse_grain (coarse_grain),
        .out_cfg      (fixed_cfg)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en && !frozen) begin
            state_d.cfg = fixed_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= entry_state_t'(RESET_CFG);
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_out = state_q.cfg;
endmodule

// File: rtl/pmpcfg_guard_chk.sv
module pmpcfg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_byte,
    input logic       lockdown,
    input logic       bypass,
    input logic       coarse_grain,
    input logic [7:0] cfg_out
);
    logic risky;
    assign risky = (wr_byte[2:0] == 3'b100) || (wr_byte[2:0] == 3'b010) ||
                   (wr_byte[2:0] == 3'b110) || (wr_byte[2:0] == 3'b101);

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_out)); // R2

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_out[7] && !bypass) |=> $stable(cfg_out)); // R3

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_out[6:5] == 2'b00)); // R5

    AST_RW_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lockdown && !(cfg_out[7] && !bypass)) |=> (cfg_out[1:0] != 2'b10)); // R6

    AST_SHARED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lockdown && !(cfg_out[7] && !bypass) && wr_byte[1:0] == 2'b10 &&
         (bypass || !wr_byte[7])) |=> (cfg_out[1:0] == 2'b10)); // R7

    AST_LOCKDOWN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lockdown && !bypass && wr_byte[7] && risky && !cfg_out[7])
        |=> (cfg_out[2:0] == $past(cfg_out[2:0]))); // R8

    AST_NO_WORD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && coarse_grain && !(cfg_out[7] && !bypass)) |=> (cfg_out[4:3] != 2'b10)); // R10
endmodule

bind pmpcfg_guard pmpcfg_guard_chk u_chk (.*);

// File: tb/pmpcfg_guard_test.sv
`timescale 1ns/1ps
module pmpcfg_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       lockdown = 1'b0;
    logic       bypass = 1'b0;
    logic       coarse_grain = 1'b0;
    logic [7:0] cfg_out;

    int checks = 0;
    int fails = 0;
    int model = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmpcfg_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .lockdown(lockdown), .bypass(bypass), .coarse_grain(coarse_grain),
        .cfg_out(cfg_out)
    );

    function automatic int ref_next(int cur, int v, bit ld, bit bp, bit g);
        int res;
        int perm;
        if (cur >= 128 && !bp) return cur;
        res  = v & 8'h9F;
        perm = res % 8;
        if (!ld && (perm == 2 || perm == 6)) res = res - 2;
        if (ld && !bp && res >= 128 && (perm == 4 || perm == 2 || perm == 6 || perm == 5))
            res = cur;
        if (g && ((res / 8) % 4) == 2) res = res - 16;
        return res;
    endfunction

    task automatic check(string tag, int expv);
        checks++;
        if (int'(cfg_out) != expv) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, cfg_out, expv[7:0]);
        end
    endtask

    task automatic step(string tag, bit we, int v, bit ld, bit bp, bit g);
        @(negedge clk);
        wr_en = we; wr_byte = v[7:0]; lockdown = ld; bypass = bp; coarse_grain = g;
        if (we) model = ref_next(model, v, ld, bp, g);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, model);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0);
        step("R2", 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1);
        step("R5", 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0);   // expect 0x1F
        step("R6", 1'b1, 8'h06, 1'b0, 1'b0, 1'b0);   // expect 0x04
        step("R7", 1'b1, 8'h02, 1'b1, 1'b0, 1'b0);   // expect 0x02
        step("R10", 1'b1, 8'h11, 1'b0, 1'b0, 1'b1);  // expect 0x01
        step("R10", 1'b1, 8'h11, 1'b0, 1'b0, 1'b0);  // expect 0x11
        step("R8", 1'b1, 8'h84, 1'b1, 1'b0, 1'b0);   // rejected, keep 0x11
        step("R8", 1'b1, 8'h82, 1'b1, 1'b0, 1'b0);
        step("R8", 1'b1, 8'h86, 1'b1, 1'b0, 1'b0);
        step("R8", 1'b1, 8'h85, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b1, 8'h84, 1'b1, 1'b0, 1'b1);  // rejected, old mode fixed: 0x01
        step("R9", 1'b1, 8'h05, 1'b1, 1'b0, 1'b0);   // L=0, accepted
        step("R9", 1'b1, 8'h85, 1'b1, 1'b1, 1'b0);   // bypass, accepted
        step("R3", 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);   // locked, keep 0x85
        step("R3", 1'b1, 8'h1F, 1'b0, 1'b0, 1'b1);
        step("R4", 1'b1, 8'h03, 1'b0, 1'b1, 1'b0);   // bypass unlocks
        step("R9", 1'b1, 8'h87, 1'b1, 1'b0, 1'b0);   // RWX 111 accepted
        step("R2", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        step("R4", 1'b1, 8'h1A, 1'b1, 1'b1, 1'b0);   // shared region via bypass
        for (int i = 0; i < 400; i++) begin
            int rv;
            rv = $urandom;
            step("R11", rv[8] | rv[9], rv[7:0], rv[10], rv[11] & rv[12], rv[13]);
        end
        done = 1'b1;
        finish_run();
    end
endmodule